// File: doc/BRIEF.md
# NOR Flash Erase and Program Sequencer

This block turns a one-shot host request into the bus traffic that a parallel NOR flash expects for two operations: programming one word (or byte) and erasing one sector. For each operation it sends the required chain of unlock and command writes, then writes the payload or the sector-erase code at the target address. It then keeps reading device status from the target address until the embedded operation is finished. Status is judged from two status bits and not from a ready pin. Bit 6 flips on every read while the device is working. Bit 5 reports that the device gave up.

A strap input tells the block that a dual-width (x8/x16) part is wired as a byte device. In that case the two unlock addresses move to their byte-mode values, and only the lower half of the data bus carries information. Every bus write is a chip-enable window around a write-enable low pulse whose length is a parameter. Address and data are set up one cycle before that pulse and held one cycle after it. The host sees `busy` for the whole operation and a single-cycle `done` or `error` at its end.

Top module: `nor_cmd_seq`

## Requirements
- R1: A program request (op_code=0) issues exactly four writes, in this order: 0x555←0xAA, 0x2AA←0x55, 0x555←0xA0, then target address←op_data.
- R2: An erase request (op_code=1) issues exactly six writes, in this order: 0x555←0xAA, 0x2AA←0x55, 0x555←0x80, 0x555←0xAA, 0x2AA←0x55, then target address←0x30.
- R3: With byte_mode=1, every write that used 0x555 uses 0xAAA instead, and every write that used 0x2AA uses 0x555 instead. Bits 15..8 of fl_dq_o are zero on every write, so a program payload keeps only op_data[7:0].
- R4: On each write, fl_ce_n is low for at least one cycle before fl_we_n falls. fl_we_n stays low for exactly WE_LOW_CYCLES cycles. fl_addr and fl_dq_o do not change while fl_we_n is low. fl_ce_n and fl_addr are still held in the cycle in which fl_we_n rises.
- R5: fl_we_n and fl_oe_n are never low at the same time. Every status read drives the target address while fl_oe_n is low.
- R6: After the last write, the operation ends with done once two consecutive status reads have equal bit 6. The number of reads is max(T+1, 2), where T is the number of reads on which the device still flips bit 6. Bit 5 is ignored when bit 6 did not flip.
- R7: If bit 6 flipped and the newer read has bit 5 set, two more status reads are made. If bit 6 differs between those two reads, the operation ends with error and without done (four reads in total).
- R8: If those two extra reads show the same bit 6, the operation ends with done and without error.
- R9: busy rises in the cycle after an accepted start. busy falls in the same cycle in which the one-cycle done or error pulse appears. done and error are never high together, and neither is high while busy.
- R10: A start pulse while busy has no effect: the running sequence's writes, read count and result are unchanged, and no further bus cycles follow its end.
- R11: While reset is held and after reset: busy, done and error are 0, and fl_we_n, fl_oe_n and fl_ce_n are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, accepted only when idle |
| op_code | input | 1 | 0 = program one word, 1 = erase sector |
| op_addr | input | AW | Target word/byte address or sector address |
| op_data | input | DW | Program payload |
| byte_mode | input | 1 | 1 = dual-width part wired for x8 operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation finished cleanly |
| error | output | 1 | One-cycle pulse: device reported failure |
| fl_addr | output | AW | Flash address bus |
| fl_dq_o | output | DW | Flash write data |
| fl_dq_i | input | DW | Flash read data (status) |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_ce_n | output | 1 | Chip enable, active low |

## Verification
busy is due one clock after the edge that samples start, so the bench looks at it one cycle after the start pulse. Each write is checked at the clock where fl_we_n rises, which comes 1 + WE_LOW_CYCLES cycles after chip enable falls. Status reads are counted at the falling edge of fl_oe_n and checked for the target address. done or error appears one cycle after the hold cycle of the last status read; the bench polls every cycle for it and checks busy, the result, the read count and an empty scoreboard in that same cycle, then checks that the pulse is gone one cycle later.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_SETUP,
        BUS_ACTIVE,
        BUS_HOLD
    } bus_st_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_POLL,
        SQ_CONFIRM
    } seq_st_e;

    typedef enum logic [1:0] {
        AK_FIRST,
        AK_SECOND,
        AK_TARGET
    } addr_kind_e;

    typedef struct packed {
        addr_kind_e kind;
        logic [7:0] code;
        logic       last;
    } step_t;

    localparam logic [7:0] CMD_KEY_A      = 8'hAA;
    localparam logic [7:0] CMD_KEY_B      = 8'h55;
    localparam logic [7:0] CMD_PROG       = 8'hA0;
    localparam logic [7:0] CMD_ERASE_PREP = 8'h80;
    localparam logic [7:0] CMD_ERASE_SECT = 8'h30;

    localparam int TOGGLE_BIT = 6;
    localparam int FAULT_BIT  = 5;

    // Unlock address: second selects the second unlock slot, byte_mode the x8 wiring.
    function automatic logic [11:0] unlock_addr(input logic second, input logic byte_mode);
        logic [11:0] a;
        case ({byte_mode, second})
            2'b00:   a = 12'h555;
            2'b01:   a = 12'h2AA;
            2'b10:   a = 12'hAAA;
            default: a = 12'h555;
        endcase
        return a;
    endfunction

    // Which address slot and code each write of a sequence uses.
    function automatic step_t step_lookup(input op_e op, input logic [2:0] idx);
        step_t s;
        if (op == OP_PROGRAM) begin
            case (idx)
                3'd0:    s = '{kind: AK_FIRST,  code: CMD_KEY_A, last: 1'b0};
                3'd1:    s = '{kind: AK_SECOND, code: CMD_KEY_B, last: 1'b0};
                3'd2:    s = '{kind: AK_FIRST,  code: CMD_PROG,  last: 1'b0};
                default: s = '{kind: AK_TARGET, code: 8'h00,     last: 1'b1};
            endcase
        end else begin
            case (idx)
                3'd0:    s = '{kind: AK_FIRST,  code: CMD_KEY_A,      last: 1'b0};
                3'd1:    s = '{kind: AK_SECOND, code: CMD_KEY_B,      last: 1'b0};
                3'd2:    s = '{kind: AK_FIRST,  code: CMD_ERASE_PREP, last: 1'b0};
                3'd3:    s = '{kind: AK_FIRST,  code: CMD_KEY_A,      last: 1'b0};
                3'd4:    s = '{kind: AK_SECOND, code: CMD_KEY_B,      last: 1'b0};
                default: s = '{kind: AK_TARGET, code: CMD_ERASE_SECT, last: 1'b1};
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/nor_step_gen.sv
module nor_step_gen
    import nor_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [2:0]    idx,
    input  logic          byte_mode,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          last
);
    localparam int HALF = DW / 2;

    step_t         s;
    logic [DW-1:0] payload;
    logic [DW-1:0] lane_mask;

    always_comb begin
        s = step_lookup(op, idx);
        case (s.kind)
            AK_FIRST:  addr = AW'(unlock_addr(1'b0, byte_mode));
            AK_SECOND: addr = AW'(unlock_addr(1'b1, byte_mode));
            default:   addr = tgt_addr;
        endcase
        if (s.kind == AK_TARGET && op == OP_PROGRAM) payload = wdata;
        else                                         payload = DW'(s.code);
        // In x8 wiring only the lower half of the bus is a live lane.
        lane_mask = byte_mode ? {{(DW-HALF){1'b0}}, {HALF{1'b1}}} : {DW{1'b1}};
        data      = payload & lane_mask;
        last      = s.last;
    end
endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
    import nor_seq_pkg::*;
#(
    parameter int AW            = 24,
    parameter int DW            = 16,
    parameter int WE_LOW_CYCLES = 3,
    parameter int READ_CYCLES   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_read,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          idle,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_o,
    input  logic [DW-1:0] fl_dq_i,
    output logic          fl_oe_n,
    output logic          fl_we_n,
    output logic          fl_ce_n
);
    localparam int MAXC = (WE_LOW_CYCLES > READ_CYCLES) ? WE_LOW_CYCLES : READ_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    bus_st_e       st;
    logic [CW-1:0] cnt;
    logic          rd_q;

    assign idle = (st == BUS_IDLE);
    assign ack  = (st == BUS_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= BUS_IDLE;
            cnt     <= '0;
            rd_q    <= 1'b0;
            rdata   <= '0;
            fl_addr <= '0;
            fl_dq_o <= '0;
            fl_oe_n <= 1'b1;
            fl_we_n <= 1'b1;
            fl_ce_n <= 1'b1;
        end else begin
            case (st)
                BUS_IDLE: begin
                    if (req) begin
                        st      <= BUS_SETUP;
                        fl_ce_n <= 1'b0;
                        fl_addr <= req_addr;
                        fl_dq_o <= req_read ? '0 : req_data;
                        rd_q    <= req_read;
                    end
                end
                BUS_SETUP: begin
                    st <= BUS_ACTIVE;
                    if (rd_q) begin
                        fl_oe_n <= 1'b0;
                        cnt     <= CW'(READ_CYCLES - 1);
                    end else begin
                        fl_we_n <= 1'b0;
                        cnt     <= CW'(WE_LOW_CYCLES - 1);
                    end
                end
                BUS_ACTIVE: begin
                    if (cnt == '0) begin
                        st      <= BUS_HOLD;
                        fl_we_n <= 1'b1;
                        fl_oe_n <= 1'b1;
                        if (rd_q) rdata <= fl_dq_i;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    st      <= BUS_IDLE;
                    fl_ce_n <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/nor_poll_judge.sv
module nor_poll_judge (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic valid,
    input  logic tog_bit,
    input  logic fault_bit,
    output logic have_prev,
    output logic toggled,
    output logic fault
);
    logic prev_tog;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev_tog  <= 1'b0;
        end else if (clr) begin
            have_prev <= 1'b0;
        end else if (valid) begin
            have_prev <= 1'b1;
            prev_tog  <= tog_bit;
        end
    end

    assign toggled = have_prev && (prev_tog != tog_bit);
    assign fault   = fault_bit;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW            = 24,
    parameter int DW            = 16,
    parameter int WE_LOW_CYCLES = 3,
    parameter int READ_CYCLES   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op_code,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_data,
    input  logic          byte_mode,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_o,
    input  logic [DW-1:0] fl_dq_i,
    output logic          fl_oe_n,
    output logic          fl_we_n,
    output logic          fl_ce_n
);
    seq_st_e       state;
    logic [2:0]    step;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          bm_q;
    logic          pending;

    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic          st_last;
    logic          bus_idle, bus_ack;
    logic [DW-1:0] rdata;
    logic          have_prev, toggled, fault;
    logic          is_read, req, accept;
    logic          finish, fin_err, go_confirm, judge_clr;
    logic          status_unused;

    nor_step_gen #(.AW(AW), .DW(DW)) u_step (
        .op        (op_q),
        .idx       (step),
        .byte_mode (bm_q),
        .tgt_addr  (addr_q),
        .wdata     (data_q),
        .addr      (st_addr),
        .data      (st_data),
        .last      (st_last)
    );

    assign is_read = (state == SQ_POLL) || (state == SQ_CONFIRM);
    assign req     = (state != SQ_IDLE) && !pending;
    assign accept  = req && bus_idle;

    nor_bus_cycle #(
        .AW(AW), .DW(DW), .WE_LOW_CYCLES(WE_LOW_CYCLES), .READ_CYCLES(READ_CYCLES)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_read (is_read),
        .req_addr (is_read ? addr_q : st_addr),
        .req_data (st_data),
        .idle     (bus_idle),
        .ack      (bus_ack),
        .rdata    (rdata),
        .fl_addr  (fl_addr),
        .fl_dq_o  (fl_dq_o),
        .fl_dq_i  (fl_dq_i),
        .fl_oe_n  (fl_oe_n),
        .fl_we_n  (fl_we_n),
        .fl_ce_n  (fl_ce_n)
    );

    // Only the two status bits take part in the verdict.
    assign status_unused = ^{rdata[DW-1:TOGGLE_BIT+1], rdata[FAULT_BIT-1:0]};

    nor_poll_judge u_judge (
        .clk       (clk),
        .rst       (rst),
        .clr       (judge_clr),
        .valid     (bus_ack && is_read),
        .tog_bit   (rdata[TOGGLE_BIT]),
        .fault_bit (rdata[FAULT_BIT]),
        .have_prev (have_prev),
        .toggled   (toggled),
        .fault     (fault)
    );

    always_comb begin
        finish     = bus_ack && have_prev &&
                     (((state == SQ_POLL) && !toggled) || (state == SQ_CONFIRM));
        fin_err    = (state == SQ_CONFIRM) && toggled;
        go_confirm = (state == SQ_POLL) && bus_ack && have_prev && toggled && fault;
        judge_clr  = ((state == SQ_CMD) && bus_ack && st_last) || go_confirm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            step    <= '0;
            op_q    <= OP_PROGRAM;
            addr_q  <= '0;
            data_q  <= '0;
            bm_q    <= 1'b0;
            pending <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            error   <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            if (accept)       pending <= 1'b1;
            else if (bus_ack) pending <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        op_q   <= op_e'(op_code);
                        addr_q <= op_addr;
                        data_q <= op_data;
                        bm_q   <= byte_mode;
                        step   <= '0;
                        busy   <= 1'b1;
                        state  <= SQ_CMD;
                    end
                end
                SQ_CMD: begin
                    if (bus_ack) begin
                        if (st_last) state <= SQ_POLL;
                        else         step  <= step + 1'b1;
                    end
                end
                SQ_POLL: begin
                    if (go_confirm) state <= SQ_CONFIRM;
                end
                default: ;
            endcase
            if (finish) begin
                state <= SQ_IDLE;
                busy  <= 1'b0;
                done  <= !fin_err;
                error <= fin_err;
            end
        end
    end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int AW            = 24,
    parameter int DW            = 16,
    parameter int WE_LOW_CYCLES = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dq_o,
    input logic          fl_oe_n,
    input logic          fl_we_n,
    input logic          fl_ce_n
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)           low_run <= '0;
        else if (!fl_we_n) low_run <= low_run + 1'b1;
        else               low_run <= '0;
    end

    a_r4_we_width: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> (low_run == 16'(WE_LOW_CYCLES)));

    a_r4_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_we_n) |-> $past(!fl_ce_n));

    a_r4_stable: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> (!fl_ce_n && $stable(fl_addr)));

    a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));

    a_r9_busy_rise: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r9_one_result: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    a_r9_result_idle: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !busy);

    a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
        (done || error) |=> !(done || error));

    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fl_we_n && fl_oe_n));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
    .AW(AW), .DW(DW), .WE_LOW_CYCLES(WE_LOW_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .error   (error),
    .fl_addr (fl_addr),
    .fl_dq_o (fl_dq_o),
    .fl_oe_n (fl_oe_n),
    .fl_we_n (fl_we_n),
    .fl_ce_n (fl_ce_n)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int WE_LOW = 3;
    localparam int RD_LEN = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          op_code = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_data = '0;
    logic          byte_mode = 1'b0;
    logic          busy, done, error;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_o, fl_dq_i;
    logic          fl_oe_n, fl_we_n, fl_ce_n;

    always #4 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .DW(DW), .WE_LOW_CYCLES(WE_LOW), .READ_CYCLES(RD_LEN)) u0 (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code), .op_addr(op_addr),
        .op_data(op_data), .byte_mode(byte_mode), .busy(busy), .done(done), .error(error),
        .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_i(fl_dq_i),
        .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_ce_n(fl_ce_n)
    );

    // Scoreboard: the driver pushes expected writes, the monitor pops them.
    logic [AW+DW-1:0] q_exp[$];
    string            q_tag[$];

    // Flash status model configuration (written by the driver only).
    int            cfg_gen = 0;
    int            cfg_toggles = 0;
    logic          cfg_fault = 1'b0;
    logic [AW-1:0] cfg_target = '0;

    // Monitor-owned state.
    int   seen_gen = 0;
    int   toggles_left = 0;
    logic tog = 1'b0;
    int   rd_count = 0;
    int   wr_count = 0;
    int   we_low = 0;
    logic prev_we = 1'b1;
    logic prev_oe = 1'b1;
    int   m_checks = 0;
    int   m_errs = 0;

    int   t_checks = 0;
    int   t_errs = 0;

    always_comb begin
        fl_dq_i = '0;
        fl_dq_i[6] = tog;
        fl_dq_i[5] = cfg_fault;
    end

    always @(negedge clk) begin
        if (cfg_gen != seen_gen) begin
            seen_gen     = cfg_gen;
            toggles_left = cfg_toggles;
            tog          = 1'b0;
        end
        if (!fl_we_n) we_low++;
        if (!prev_we && fl_we_n) begin
            wr_count++;
            m_checks++;
            if (we_low != WE_LOW || fl_ce_n) begin
                m_errs++;
                $display("FAIL R4 write strobe: low=%0d ce_n=%0b expected low=%0d ce_n=0",
                         we_low, fl_ce_n, WE_LOW);
            end
            m_checks++;
            if (q_exp.size() == 0) begin
                m_errs++;
                $display("FAIL R10 unexpected write: addr=%h data=%h expected none",
                         fl_addr, fl_dq_o);
            end else begin
                logic [AW+DW-1:0] e;
                string            t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if ({fl_addr, fl_dq_o} != e) begin
                    m_errs++;
                    $display("FAIL %s write: addr=%h data=%h expected addr=%h data=%h",
                             t, fl_addr, fl_dq_o, e[AW+DW-1:DW], e[DW-1:0]);
                end
            end
        end
        if (fl_we_n) we_low = 0;
        if (prev_oe && !fl_oe_n) begin
            rd_count++;
            if (toggles_left > 0) begin
                tog = ~tog;
                toggles_left--;
            end
            m_checks++;
            if (fl_addr != cfg_target || !fl_we_n) begin
                m_errs++;
                $display("FAIL R5 status read: addr=%h we_n=%0b expected addr=%h we_n=1",
                         fl_addr, fl_we_n, cfg_target);
            end
        end
        prev_we = fl_we_n;
        prev_oe = fl_oe_n;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        t_checks++;
        if (!ok) begin
            t_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] a, input logic [DW-1:0] d, input string tag);
        q_exp.push_back({AW'(a), d});
        q_tag.push_back(tag);
    endtask

    task automatic run_op(input logic op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic bm, input int toggles, input logic fault,
                          input logic exp_err, input int exp_reads,
                          input string tag, input bit poke);
        logic [11:0]   u1, u2;
        logic [DW-1:0] dd;
        int            rd_base, wr_base, n_wr, cyc;
        u1 = bm ? 12'hAAA : 12'h555;
        u2 = bm ? 12'h555 : 12'h2AA;
        dd = bm ? {8'h00, d[7:0]} : d;
        if (op == 1'b0) begin
            push(u1, 16'h00AA, tag); push(u2, 16'h0055, tag); push(u1, 16'h00A0, tag);
            q_exp.push_back({a, dd}); q_tag.push_back(tag);
            n_wr = 4;
        end else begin
            push(u1, 16'h00AA, tag); push(u2, 16'h0055, tag); push(u1, 16'h0080, tag);
            push(u1, 16'h00AA, tag); push(u2, 16'h0055, tag);
            q_exp.push_back({a, 16'h0030}); q_tag.push_back(tag);
            n_wr = 6;
        end
        cfg_toggles = toggles;
        cfg_fault   = fault;
        cfg_target  = a;
        cfg_gen++;
        @(negedge clk);
        rd_base = rd_count;
        wr_base = wr_count;
        op_code = op; op_addr = a; op_data = d; byte_mode = bm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", "busy after start", busy, 1);
        if (poke) begin
            repeat (6) @(negedge clk);
            op_code = ~op; op_addr = a ^ 24'h00F0F0; op_data = ~d; byte_mode = ~bm;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!(done || error) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc < 20000, tag, "watchdog: no result", cyc, 0);
        check(error == exp_err, tag, "error flag", error, exp_err);
        check(done == !exp_err, tag, "done flag", done, !exp_err);
        check(busy == 1'b0, "R9", "busy at result", busy, 0);
        check(rd_count - rd_base == exp_reads, tag, "status read count",
              rd_count - rd_base, exp_reads);
        check(wr_count - wr_base == n_wr, tag, "write count", wr_count - wr_base, n_wr);
        check(q_exp.size() == 0, tag, "writes left in scoreboard", q_exp.size(), 0);
        @(negedge clk);
        check(!done && !error, "R9", "result pulse length", {done, error}, 0);
        if (poke) begin
            wr_base = wr_count;
            rd_base = rd_count;
            repeat (20) @(negedge clk);
            check(wr_count == wr_base && rd_count == rd_base && !busy, "R10",
                  "bus activity after ignored start", wr_count - wr_base, 0);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !error, "R11", "status in reset", {busy, done, error}, 0);
        check(fl_we_n && fl_oe_n && fl_ce_n, "R11", "strobes in reset",
              {fl_we_n, fl_oe_n, fl_ce_n}, 3'b111);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && fl_we_n && fl_oe_n && fl_ce_n, "R11", "state after reset",
              {busy, fl_we_n, fl_oe_n, fl_ce_n}, 4'b0111);

        run_op(1'b0, 24'h012345, 16'hBEEF, 1'b0, 0, 1'b0, 1'b0, 2, "R1", 1'b0);
        run_op(1'b0, 24'h000100, 16'h1234, 1'b0, 5, 1'b0, 1'b0, 6, "R6", 1'b0);
        run_op(1'b1, 24'h040000, 16'h0000, 1'b0, 3, 1'b0, 1'b0, 4, "R2", 1'b0);
        run_op(1'b0, 24'h00ABCD, 16'hBEEF, 1'b1, 2, 1'b0, 1'b0, 3, "R3", 1'b0);
        run_op(1'b1, 24'h020000, 16'h0000, 1'b1, 0, 1'b0, 1'b0, 2, "R3", 1'b0);
        run_op(1'b0, 24'h000777, 16'h5A5A, 1'b0, 100, 1'b1, 1'b1, 4, "R7", 1'b0);
        run_op(1'b1, 24'h060000, 16'h0000, 1'b0, 2, 1'b1, 1'b0, 4, "R8", 1'b0);
        run_op(1'b0, 24'h000888, 16'hC3C3, 1'b0, 1, 1'b1, 1'b0, 2, "R6", 1'b0);
        run_op(1'b0, 24'h000999, 16'h7E81, 1'b0, 4, 1'b0, 1'b0, 5, "R10", 1'b1);

        $display("Result: errors=%0d of %0d checks", t_errs + m_errs, t_checks + m_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", t_errs + m_errs + 1,
                 t_checks + m_checks + 1);
        $finish;
    end
endmodule